// File: doc/BRIEF.md
# Master Serial Bitstream Loader

This block pulls a configuration bitstream out of one or more cascaded serial boot memories and hands it to an on-chip configuration sink as a stream of parallel words. It sits idle until the memory's ready line rises, provided the mode-select input chooses external serial loading. It then pulls its three control lines low and runs a divided serial clock. It takes one data bit per clock period until the set bitstream length has arrived.

After the last bit, the serial clock finishes its final high phase and then stops low. The chip-enable, memory-reset and done lines all return high. The memory-reset line stays high between loads, so every cascaded memory clears its address pointer, and the next load starts again from the first bit. Bits are packed first-received-first into the top bit of each word. Each full word is offered for one system-clock cycle.

The serial clock half period is `CLK_DIV` system cycles. At a 200 MHz system clock the default of 8 gives 12.5 MHz, which is within the limit for cascaded memories and gives 40 ns high and low times. `BIT_COUNT` must be a whole multiple of `WORD_W`.

Top module: `cfg_serial_loader`

## Requirements
- R1: While reset is asserted and right after it is released, cclk_o=0, cce_o=1, reset_o=1, done_o=0 and word_valid_o=0.
- R2: A load begins on a rising edge of ready_i seen while idle with mode_sel_i=1. Within a few system cycles, cce_o, reset_o and done_o are all driven low together.
- R3: With mode_sel_i=0, a rising edge of ready_i has no effect: cce_o stays 1 and cclk_o makes no edge.
- R4: During a load, every high phase of cclk_o lasts exactly CLK_DIV system cycles, and so does every low phase after the first rising edge. Outside a load, cclk_o is held at 0.
- R5: data_i is sampled at each cclk_o rising edge. A load produces exactly BIT_COUNT rising edges of cclk_o.
- R6: Received bits are packed into WORD_W-bit words, with the first bit of each word placed at bit WORD_W-1. Each word appears on word_data_o with a one-cycle word_valid_o pulse, giving BIT_COUNT/WORD_W pulses per load.
- R7: At the end of a load, cclk_o falls after its last high phase and stays 0, and cce_o, reset_o and done_o are all driven to 1.
- R8: A rising edge of ready_i that arrives during a load is ignored. The load completes normally and no second load follows it.
- R9: Because reset_o stays high between loads, a second load of the same memory content yields the same word sequence as the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_sel_i | input | 1 | 1 selects loading from external serial memory |
| ready_i | input | 1 | Ready/reconfigure line from memory; a rising edge requests a load |
| data_i | input | 1 | Serial data from the memory chain |
| cclk_o | output | 1 | Serial clock to the memories |
| cce_o | output | 1 | Memory chip enable, active low |
| reset_o | output | 1 | Memory reset/output-enable; high clears address pointers |
| done_o | output | 1 | High once a load has completed |
| word_valid_o | output | 1 | One-cycle strobe for each completed word |
| word_data_o | output | WORD_W | Packed configuration word |

## Verification
A wrong state or a wrong bit count shows up at the end of a load. The number of serial clock edges is off, or done and the control lines return high too early or never. Either is visible within one load of about BIT_COUNT*2*CLK_DIV cycles. A wrong sample instant or packing order corrupts word contents from the first strobe onward. A missing memory reset between loads is exposed only on the repeated load, where every word shifts. Stray starts from an ignored edge appear as controls falling again after done.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_TAIL = 2'd2
  } ld_state_e;
endpackage

// File: rtl/cfg_edge_sync.sv
module cfg_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/cfg_cclk_div.sv
module cfg_cclk_div #(
  parameter int DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic cclk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic          cclk_q;
  logic          tick;

  assign tick   = en_i && (cnt_q == CW'(DIV - 1));
  assign rise_o = tick && !cclk_q;
  assign fall_o = tick && cclk_q;
  assign cclk_o = cclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      cclk_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      cclk_q <= 1'b0;
    end else if (tick) begin
      cnt_q  <= '0;
      cclk_q <= ~cclk_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  // R4
  cclk_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !cclk_o);
endmodule

// File: rtl/cfg_word_pack.sv
module cfg_word_pack #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         sample_i,
  input  logic         bit_i,
  output logic         valid_o,
  output logic [W-1:0] word_o
);
  localparam int CW = $clog2(W);

  logic [W-2:0]  sr_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q    <= '0;
      cnt_q   <= '0;
      valid_o <= 1'b0;
      word_o  <= '0;
    end else begin
      valid_o <= 1'b0;
      if (clr_i) begin
        cnt_q <= '0;
      end else if (sample_i) begin
        sr_q <= {sr_q[W-3:0], bit_i};
        if (cnt_q == CW'(W - 1)) begin
          cnt_q   <= '0;
          valid_o <= 1'b1;
          word_o  <= {sr_q, bit_i};
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R6
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
  import cfg_loader_pkg::*;
#(
  parameter int CLK_DIV     = 8,
  parameter int BIT_COUNT   = 64,
  parameter int WORD_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_sel_i,
  input  logic              ready_i,
  input  logic              data_i,
  output logic              cclk_o,
  output logic              cce_o,
  output logic              reset_o,
  output logic              done_o,
  output logic              word_valid_o,
  output logic [WORD_W-1:0] word_data_o
);
  localparam int BCW = $clog2(BIT_COUNT + 1);

  ld_state_e      st_q;
  logic [BCW-1:0] bit_cnt_q;
  logic           cce_q, rst_q, done_q;
  logic           rdy_rise, start;
  logic           div_en, cclk_rise, cclk_fall, sample;

  cfg_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (ready_i),
    .rise_o (rdy_rise)
  );

  assign start  = rdy_rise && mode_sel_i && (st_q == ST_IDLE);
  assign div_en = (st_q != ST_IDLE);
  assign sample = cclk_rise && (st_q == ST_LOAD);

  cfg_cclk_div #(.DIV(CLK_DIV)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (div_en),
    .cclk_o (cclk_o),
    .rise_o (cclk_rise),
    .fall_o (cclk_fall)
  );

  cfg_word_pack #(.W(WORD_W)) u_pack (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (start),
    .sample_i (sample),
    .bit_i    (data_i),
    .valid_o  (word_valid_o),
    .word_o   (word_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      bit_cnt_q <= '0;
      cce_q     <= 1'b1;
      rst_q     <= 1'b1;
      done_q    <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start) begin
          st_q      <= ST_LOAD;
          bit_cnt_q <= '0;
          cce_q     <= 1'b0;
          rst_q     <= 1'b0;
          done_q    <= 1'b0;
        end
        ST_LOAD: if (cclk_rise) begin
          bit_cnt_q <= bit_cnt_q + 1'b1;
          if (bit_cnt_q == BCW'(BIT_COUNT - 1)) st_q <= ST_TAIL;
        end
        ST_TAIL: if (cclk_fall) begin
          st_q   <= ST_IDLE;
          cce_q  <= 1'b1;
          rst_q  <= 1'b1;
          done_q <= 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cce_o   = cce_q;
  assign reset_o = rst_q;
  assign done_o  = done_q;

  // R7
  done_ctrl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (cce_q && rst_q));

  // R4
  cclk_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cclk_o |-> !cce_q);

  // R3
  mode_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cce_q) |-> $past(mode_sel_i));

  // R5
  bit_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt_q <= BCW'(BIT_COUNT));

  // R8
  no_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LOAD) |=> (st_q != ST_IDLE));
endmodule

// File: tb/sim_cfg_serial_loader.sv
`timescale 1ns/1ps
module sim_cfg_serial_loader;
  localparam int DIV = 8;
  localparam int NB  = 64;
  localparam int W   = 8;
  localparam int NW  = NB / W;
  localparam int NV  = 4;

  // {ready glitch during load, memory content}
  localparam logic [NB:0] VEC [NV] = '{
    {1'b0, 64'hA5C3_0FF0_1234_8001},
    {1'b0, 64'hFFFF_0000_FFFF_0000},
    {1'b1, 64'h0123_4567_89AB_CDEF},
    {1'b0, 64'h0123_4567_89AB_CDEF}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic mode_sel_i = 1'b1;
  logic ready_i = 1'b0;
  logic data_i;
  logic cclk_o, cce_o, reset_o, done_o, word_valid_o;
  logic [W-1:0] word_data_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cfg_serial_loader #(.CLK_DIV(DIV), .BIT_COUNT(NB), .WORD_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .mode_sel_i(mode_sel_i), .ready_i(ready_i),
    .data_i(data_i), .cclk_o(cclk_o), .cce_o(cce_o), .reset_o(reset_o),
    .done_o(done_o), .word_valid_o(word_valid_o), .word_data_o(word_data_o)
  );

  // serial memory model: pointer clears while reset_o high, advances on cclk rise
  logic [NB-1:0] mem = '0;
  int ptr = 0;
  always @(posedge cclk_o or posedge reset_o)
    if (reset_o) ptr <= 0;
    else         ptr <= ptr + 1;
  assign data_i = (ptr < NB) ? mem[NB-1-ptr] : 1'b0;

  // monitor
  logic [W-1:0] cap [2*NW];
  int ncap = 0, nrise = 0, run_len = 0, wbad = 0;
  logic cclk_prev = 1'b0;
  always @(negedge clk) begin
    if (word_valid_o) begin
      if (ncap < 2*NW) cap[ncap] = word_data_o;
      ncap++;
    end
    if (cclk_o !== cclk_prev) begin
      if ((cclk_prev === 1'b1 || nrise > 0) && run_len != DIV) wbad++;
      if (cclk_o === 1'b1) nrise++;
      run_len = 1;
    end else begin
      run_len++;
    end
    cclk_prev = cclk_o;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    end
  endtask

  task automatic do_load(input logic [NB-1:0] pat, input bit glitch, input string wreq);
    int t;
    mem = pat; ncap = 0; nrise = 0; wbad = 0;
    ready_i = 1'b0;
    repeat (4) @(negedge clk);
    ready_i = 1'b1;
    t = 0;
    while (cce_o && t < 20) begin @(negedge clk); t++; end
    // R2
    chk({cce_o, reset_o, done_o} == 3'b000, "R2", {cce_o, reset_o, done_o}, 0);
    if (glitch) begin
      repeat (100) @(negedge clk);
      ready_i = 1'b0;
      repeat (4) @(negedge clk);
      ready_i = 1'b1;
    end
    t = 0;
    while (!done_o && t < 5000) begin @(negedge clk); t++; end
    // R7
    chk({done_o, cce_o, reset_o, cclk_o} == 4'b1110, "R7",
        {done_o, cce_o, reset_o, cclk_o}, 4'b1110);
    repeat (60) @(negedge clk);
    // R8: controls stay released, no further clocking
    if (glitch) chk(done_o && cce_o && nrise == NB, "R8", {done_o, cce_o}, 2'b11);
    // R5
    chk(nrise == NB, "R5", nrise, NB);
    // R4
    chk(wbad == 0, "R4", wbad, 0);
    // R6
    chk(ncap == NW, "R6", ncap, NW);
    for (int k = 0; k < NW; k++)
      chk(cap[k] == pat[NB-1-k*W -: W], wreq, cap[k], pat[NB-1-k*W -: W]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1: during reset
    chk({cclk_o, cce_o, reset_o, done_o, word_valid_o} == 5'b01100, "R1",
        {cclk_o, cce_o, reset_o, done_o, word_valid_o}, 5'b01100);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    // R1: after release
    chk({cclk_o, cce_o, reset_o, done_o, word_valid_o} == 5'b01100, "R1",
        {cclk_o, cce_o, reset_o, done_o, word_valid_o}, 5'b01100);

    // R3: edge with mode_sel low is ignored
    mode_sel_i = 1'b0; nrise = 0;
    ready_i = 1'b1;
    repeat (60) @(negedge clk);
    chk(cce_o && nrise == 0, "R3", {cce_o, 8'(nrise)}, 9'h100);
    ready_i = 1'b0;
    mode_sel_i = 1'b1;
    repeat (5) @(negedge clk);

    // vector table; last entry repeats content for R9
    for (int i = 0; i < NV; i++)
      do_load(VEC[i][NB-1:0], VEC[i][NB], (i == NV-1) ? "R9" : "R6");

    // R1: reset during a load returns to idle levels
    mem = '1;
    ready_i = 1'b0;
    repeat (4) @(negedge clk);
    ready_i = 1'b1;
    repeat (200) @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    chk({cclk_o, cce_o, reset_o, done_o, word_valid_o} == 5'b01100, "R1",
        {cclk_o, cce_o, reset_o, done_o, word_valid_o}, 5'b01100);
    ready_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    // R9: load after reset still starts at first bit
    do_load(64'hDEAD_BEEF_5A5A_0F0F, 1'b0, "R9");

    summary();
    $finish;
  end
endmodule